// File: doc/BRIEF.md
# Tiled Background Pixel Fetch Unit

This block finds the palette color index of one background pixel in a tile-based video pipeline. Each cycle it takes a screen pixel position and a scroll offset and works out where that pixel falls on the background canvas. It then looks up the attribute entry of the tile that covers that spot. It applies the tile's two mirror bits to the position inside the tile, and reads the graphics word that holds the pixel. The output is the tile's palette number joined to the 3-bit pixel value.

Tiles are 16 by 16 pixels. The attribute map is 40 tiles wide. Graphics words are 15 bits wide and pack five 3-bit pixels each, so a tile takes 52 words. The block reaches two external synchronous memories through plain address-out / data-in ports, and each of them has one cycle of read latency. The pipeline accepts a new pixel position on every cycle and returns its result a fixed number of cycles later.

Top module: `tbg_fetch`

## Requirements
- R1: The canvas position is (pixX + shX) mod 2^XW and (pixY + shY) mod 2^YW. The tile column is canvas X / 16 and the tile row is canvas Y / 16. attrAddr = tileRow × 40 + tileColumn.
- R2: The fields of an attribute word are laid out as follows:
  - bits 9:0 hold the graphics index.
  - bits 12:10 hold the palette number.
  - bit 13 is the column mirror.
  - bit 14 is the row mirror.
- R3: When bit 14 of the attribute word is set, the in-tile row (canvas Y mod 16) becomes 15 minus its value.
- R4: When bit 13 of the attribute word is set, the in-tile column (canvas X mod 16) becomes 15 minus its value. When both mirror bits are set, both mirrors apply.
- R5: pixel index = row × 16 + column, and tileAddr = graphicsIndex × 52 + pixel index / 5.
- R6: The pixel value is taken from tileData bits 3n+2 down to 3n, where n = pixel index mod 5.
- R7: cidx = palette × 8 + pixel value, a 6-bit result.
- R8: The block accepts one position per cycle. attrAddr reflects the inputs sampled at the previous clock edge. tileAddr reflects the inputs sampled three edges earlier. cidx reflects the inputs sampled five edges earlier.
- R9: If oe is low at a clock edge, cidx is 0 after that edge.
- R10: A synchronous reset clears attrAddr, tileAddr and cidx. cidx then stays 0 for the first five edges after reset is released, until the pipeline is full.
- R11: With screen (25,60), shift (3,3), attribute word 0x4814 and graphics word 0x7E3F, the results are attrAddr = 121, tileAddr = 1042 and cidx = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oe | input | 1 | Output enable for cidx |
| pixX | input | XW (10) | Screen pixel column |
| pixY | input | YW (9) | Screen pixel row |
| shX | input | XW (10) | Horizontal scroll offset |
| shY | input | YW (9) | Vertical scroll offset |
| attrAddr | output | 11 | Attribute memory read address |
| attrData | input | 15 | Attribute memory read data, one cycle after the address |
| tileAddr | output | 16 | Graphics memory read address |
| tileData | input | 15 | Graphics memory read data, one cycle after the address |
| cidx | output | 6 | Palette color index |

## Verification
A long stream of positions, one per cycle, walks every in-tile column, row and word slot under changing scroll offsets. Memory contents are hashed, so all four mirror combinations and every palette appear. Comparing both addresses and cidx at their own latencies separates a wrong tile number or mirror from a wrong word offset or bit select. Bursts of low oe, a mid-run reset and two directed cases with fixed memory words round this out. The first directed case uses the known example. The second sets both mirror bits, and the tile address alone shows whether the column mirror was applied.

// File: rtl/tbg_fetch_pkg.sv
package tbg_fetch_pkg;
  // Pipeline: attr addr, attr data, tile addr, tile data, output
  localparam int PIPE_DEPTH = 5;

  typedef struct packed {
    logic advance;  // pipeline stages load new values
    logic drive;    // output register loads a color, else zero
  } pipeStrobe_t;
endpackage

// File: rtl/tbg_fetch_ctrl.sv
module tbg_fetch_ctrl
  import tbg_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        oe,
  output pipeStrobe_t strobe
);
  localparam int CNT_W = $clog2(PIPE_DEPTH);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PIPE_DEPTH - 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    strobe.advance = ~rst;
    strobe.drive   = (fillCnt == FULL) && oe;
  end
endmodule

// File: rtl/tbg_fetch_dp.sv
module tbg_fetch_dp
  import tbg_fetch_pkg::*;
#(
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int MAP_COLS  = 40,
  parameter int TILE_LOG2 = 4,
  parameter int IDX_W     = 10,
  parameter int PAL_W     = 3,
  parameter int BPP       = 3,
  parameter int WORD_W    = 15
)(
  input  logic                clk,
  input  logic                rst,
  input  pipeStrobe_t         strobe,
  input  logic [XW-1:0]       pixX,
  input  logic [YW-1:0]       pixY,
  input  logic [XW-1:0]       shX,
  input  logic [YW-1:0]       shY,
  output logic [$clog2(((1<<(YW-TILE_LOG2))-1)*MAP_COLS + (1<<(XW-TILE_LOG2)))-1:0] attrAddr,
  input  logic [IDX_W+PAL_W+1:0] attrData,
  output logic [$clog2((1<<IDX_W)*(((1<<(2*TILE_LOG2))+(WORD_W/BPP)-1)/(WORD_W/BPP)))-1:0] tileAddr,
  input  logic [WORD_W-1:0]   tileData,
  output logic [PAL_W+BPP-1:0] cidx
);
  localparam int TL         = TILE_LOG2;
  localparam int PPW        = WORD_W / BPP;
  localparam int TILE_PIX   = 1 << (2 * TL);
  localparam int TILE_WORDS = (TILE_PIX + PPW - 1) / PPW;
  localparam int ATTR_AW    = $clog2(((1<<(YW-TL))-1)*MAP_COLS + (1<<(XW-TL)));
  localparam int TM_AW      = $clog2((1<<IDX_W)*TILE_WORDS);
  localparam int SEL_W      = (PPW > 1) ? $clog2(PPW) : 1;
  localparam int COLMIR_BIT = IDX_W + PAL_W;
  localparam int ROWMIR_BIT = IDX_W + PAL_W + 1;

  // Stage 0 (combinational): canvas position
  logic [XW-1:0] absX;
  logic [YW-1:0] absY;
  always_comb begin
    absX = pixX + shX;
    absY = pixY + shY;
  end

  // Stage 1: attribute address and in-tile position
  logic [ATTR_AW-1:0] attrAddrQ;
  logic [TL-1:0]      locX1, locY1, locX2, locY2;
  always_ff @(posedge clk) begin
    if (rst) begin
      attrAddrQ <= '0;
      locX1 <= '0; locY1 <= '0;
      locX2 <= '0; locY2 <= '0;
    end else if (strobe.advance) begin
      attrAddrQ <= ATTR_AW'(int'(absY[YW-1:TL]) * MAP_COLS + int'(absX[XW-1:TL]));
      locX1 <= absX[TL-1:0];
      locY1 <= absY[TL-1:0];
      locX2 <= locX1;           // stage 2: wait for attribute data
      locY2 <= locY1;
    end
  end

  // Stage 3 (inputs): mirrors and word selection
  logic [TL-1:0]   colEff, rowEff;
  logic [2*TL-1:0] pixIdx;
  always_comb begin
    rowEff = attrData[ROWMIR_BIT] ? ~locY2 : locY2;
    colEff = attrData[COLMIR_BIT] ? ~locX2 : locX2;
    pixIdx = {rowEff, colEff};
  end

  logic [TM_AW-1:0] tileAddrQ;
  logic [PAL_W-1:0] pal3, pal4;
  logic [SEL_W-1:0] sel3, sel4;
  always_ff @(posedge clk) begin
    if (rst) begin
      tileAddrQ <= '0;
      pal3 <= '0; sel3 <= '0;
      pal4 <= '0; sel4 <= '0;
    end else if (strobe.advance) begin
      tileAddrQ <= TM_AW'(int'(attrData[IDX_W-1:0]) * TILE_WORDS + int'(pixIdx) / PPW);
      pal3 <= attrData[IDX_W +: PAL_W];
      sel3 <= SEL_W'(int'(pixIdx) % PPW);
      pal4 <= pal3;              // stage 4: wait for tile data
      sel4 <= sel3;
    end
  end

  // Stage 5: pixel extract and output
  logic [WORD_W-1:0] shifted;
  always_comb shifted = tileData >> (BPP * int'(sel4));

  logic [PAL_W+BPP-1:0] cidxQ;
  always_ff @(posedge clk) begin
    if (rst) cidxQ <= '0;
    else if (strobe.advance) cidxQ <= strobe.drive ? {pal4, shifted[BPP-1:0]} : '0;
  end

  assign attrAddr = attrAddrQ;
  assign tileAddr = tileAddrQ;
  assign cidx     = cidxQ;
endmodule

// File: rtl/tbg_fetch.sv
module tbg_fetch
  import tbg_fetch_pkg::*;
#(
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int MAP_COLS  = 40,
  parameter int TILE_LOG2 = 4,
  parameter int IDX_W     = 10,
  parameter int PAL_W     = 3,
  parameter int BPP       = 3,
  parameter int WORD_W    = 15,
  localparam int PPW        = WORD_W / BPP,
  localparam int TILE_WORDS = ((1 << (2*TILE_LOG2)) + PPW - 1) / PPW,
  localparam int ATTR_AW    = $clog2(((1<<(YW-TILE_LOG2))-1)*MAP_COLS + (1<<(XW-TILE_LOG2))),
  localparam int TM_AW      = $clog2((1<<IDX_W)*TILE_WORDS),
  localparam int ATTR_W     = IDX_W + PAL_W + 2,
  localparam int CIDX_W     = PAL_W + BPP
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               oe,
  input  logic [XW-1:0]      pixX,
  input  logic [YW-1:0]      pixY,
  input  logic [XW-1:0]      shX,
  input  logic [YW-1:0]      shY,
  output logic [ATTR_AW-1:0] attrAddr,
  input  logic [ATTR_W-1:0]  attrData,
  output logic [TM_AW-1:0]   tileAddr,
  input  logic [WORD_W-1:0]  tileData,
  output logic [CIDX_W-1:0]  cidx
);
  pipeStrobe_t strobe;

  tbg_fetch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .oe(oe), .strobe(strobe)
  );

  tbg_fetch_dp #(
    .XW(XW), .YW(YW), .MAP_COLS(MAP_COLS), .TILE_LOG2(TILE_LOG2),
    .IDX_W(IDX_W), .PAL_W(PAL_W), .BPP(BPP), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .pixX(pixX), .pixY(pixY), .shX(shX), .shY(shY),
    .attrAddr(attrAddr), .attrData(attrData),
    .tileAddr(tileAddr), .tileData(tileData),
    .cidx(cidx)
  );
endmodule

// File: rtl/tbg_fetch_chk.sv
module tbg_fetch_chk #(
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int MAP_COLS  = 40,
  parameter int TILE_LOG2 = 4,
  parameter int IDX_W     = 10,
  parameter int PAL_W     = 3,
  parameter int BPP       = 3,
  parameter int WORD_W    = 15
)(
  input logic clk,
  input logic rst,
  input logic oe,
  input logic [XW-1:0] pixX,
  input logic [YW-1:0] pixY,
  input logic [XW-1:0] shX,
  input logic [YW-1:0] shY,
  input logic [$clog2(((1<<(YW-TILE_LOG2))-1)*MAP_COLS + (1<<(XW-TILE_LOG2)))-1:0] attrAddr,
  input logic [IDX_W+PAL_W+1:0] attrData,
  input logic [$clog2((1<<IDX_W)*(((1<<(2*TILE_LOG2))+(WORD_W/BPP)-1)/(WORD_W/BPP)))-1:0] tileAddr,
  input logic [WORD_W-1:0] tileData,
  input logic [PAL_W+BPP-1:0] cidx
);
  localparam int PPW        = WORD_W / BPP;
  localparam int TILE_WORDS = ((1 << (2*TILE_LOG2)) + PPW - 1) / PPW;

  // Edges seen since reset release, saturating
  logic [3:0] edges;
  always_ff @(posedge clk) begin
    if (rst) edges <= '0;
    else if (edges != 4'd15) edges <= edges + 4'd1;
  end

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (cidx == '0 && attrAddr == '0 && tileAddr == '0));

  a_r10_fill_zero: assert property (@(posedge clk) disable iff (rst)
    (edges < 4'd5) |-> cidx == '0);

  a_r9_oe_low_zero: assert property (@(posedge clk) disable iff (rst)
    !oe |=> cidx == '0);

  a_r7_palette_field: assert property (@(posedge clk) disable iff (rst)
    (edges >= 4'd6 && $past(oe)) |->
      cidx[PAL_W+BPP-1:BPP] == $past(attrData[IDX_W +: PAL_W], 3));

  a_r5_tile_base: assert property (@(posedge clk) disable iff (rst)
    (edges >= 4'd2) |->
      (int'(tileAddr) / TILE_WORDS) == int'($past(attrData[IDX_W-1:0])));

  a_r8_attr_hold: assert property (@(posedge clk) disable iff (rst)
    (edges >= 4'd3 && $past(pixX) == $past(pixX, 2) && $past(pixY) == $past(pixY, 2) &&
     $past(shX) == $past(shX, 2) && $past(shY) == $past(shY, 2)) |-> $stable(attrAddr));
endmodule

bind tbg_fetch tbg_fetch_chk #(
  .XW(XW), .YW(YW), .MAP_COLS(MAP_COLS), .TILE_LOG2(TILE_LOG2),
  .IDX_W(IDX_W), .PAL_W(PAL_W), .BPP(BPP), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/sim_tbg_fetch.sv
module sim_tbg_fetch;
  localparam int NV = 1600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oe  = 1'b0;
  logic [9:0]  pixX = '0, shX = '0;
  logic [8:0]  pixY = '0, shY = '0;
  logic [10:0] attrAddr;
  logic [14:0] attrData;
  logic [15:0] tileAddr;
  logic [14:0] tileData;
  logic [5:0]  cidx;

  int nErr = 0;
  int nChk = 0;
  bit exMode = 1'b0;
  logic [14:0] exAttr = '0, exTile = '0;

  always #2 clk = ~clk;

  tbg_fetch u0 (
    .clk(clk), .rst(rst), .oe(oe), .pixX(pixX), .pixY(pixY), .shX(shX), .shY(shY),
    .attrAddr(attrAddr), .attrData(attrData), .tileAddr(tileAddr),
    .tileData(tileData), .cidx(cidx)
  );

  function automatic logic [14:0] attrFn(input int a);
    logic [31:0] h;
    h = 32'(a + 1) * 32'h9E3779B1;
    return h[22:8];
  endfunction

  function automatic logic [14:0] tileFn(input int a);
    logic [31:0] h;
    h = 32'(a + 3) * 32'h85EBCA6B;
    return h[26:12];
  endfunction

  // Synchronous memory models, one cycle of latency
  always_ff @(posedge clk) begin
    attrData <= exMode ? exAttr : attrFn(int'(attrAddr));
    tileData <= exMode ? exTile : tileFn(int'(tileAddr));
  end

  // Reference: computed from the requirements
  task automatic model(input int x, y, sx, sy, output int aa, ta, cc);
    int ax, ay, lx, ly, p, pix;
    logic [14:0] w, t;
    ax = (x + sx) % 1024;  ay = (y + sy) % 512;          // R1
    aa = (ay / 16) * 40 + ax / 16;
    w  = attrFn(aa);
    lx = ax % 16;  ly = ay % 16;
    if (w[14]) ly = 15 - ly;                              // R3
    if (w[13]) lx = 15 - lx;                              // R4
    p  = ly * 16 + lx;                                    // R5
    ta = int'(w[9:0]) * 52 + p / 5;
    t  = tileFn(ta);
    pix = int'((t >> (3 * (p % 5))) & 15'd7);             // R6
    cc = int'(w[12:10]) * 8 + pix;                        // R7, R2
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  int expA[NV], expT[NV], expC[NV];
  bit oeArr[NV + 8];

  // Directed case with fixed memory words
  task automatic directed(input int x, y, sx, sy, input logic [14:0] aw, tw,
                          input int ea, et, ec, input string tag);
    @(negedge clk);
    rst = 1'b1; exMode = 1'b1; exAttr = aw; exTile = tw; oe = 1'b1;
    pixX = 10'(x); pixY = 9'(y); shX = 10'(sx); shY = 9'(sy);
    @(negedge clk);
    chk("R10 reset cidx", int'(cidx), 0);
    chk("R10 reset tileAddr", int'(tileAddr), 0);
    rst = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) chk({tag, " attrAddr"}, int'(attrAddr), ea);
      if (k == 3) chk({tag, " tileAddr"}, int'(tileAddr), et);
      if (k < 5) chk("R10 fill zero", int'(cidx), 0);
      else chk({tag, " cidx"}, int'(cidx), ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset attrAddr", int'(attrAddr), 0);
    chk("R10 reset cidx", int'(cidx), 0);

    // Streaming sweep, one position per cycle
    for (int i = 0; i < NV + 6; i++) begin
      @(negedge clk);
      if (i == 0) rst = 1'b0;
      if (i >= 1 && i <= NV) chk("R1 R8 attrAddr", int'(attrAddr), expA[i-1]);
      if (i >= 3 && i < NV + 3) chk("R5 R8 tileAddr", int'(tileAddr), expT[i-3]);
      if (i < 5) chk("R10 fill zero", int'(cidx), 0);
      else if (i < NV + 5) begin
        if (oeArr[i-1]) chk("R7 R8 cidx", int'(cidx), expC[i-5]);
        else chk("R9 oe low", int'(cidx), 0);
      end
      if (i < NV) begin
        int x, y, sx, sy;
        x  = (i * 3 + i / 64) % 1024;
        y  = (i * 5 + i / 16) % 512;
        sx = ((i / 256) * 37) % 1024;
        sy = ((i / 256) * 11) % 512;
        pixX = 10'(x); pixY = 9'(y); shX = 10'(sx); shY = 9'(sy);
        model(x, y, sx, sy, expA[i], expT[i], expC[i]);
        oe = !((i >= 1200 && i < 1230) || (i % 97 == 13));
      end
      oeArr[i] = oe;
    end

    // R11 worked example
    directed(25, 60, 3, 3, 15'h4814, 15'h7E3F, 121, 1042, 16, "R11");
    // R4: both mirrors set, palette 5, graphics index 7
    directed(5, 9, 0, 0, 15'h7407, 15'h5555, 0, 385, 42, "R4");

    // R9: oe low with a full pipeline
    @(negedge clk); oe = 1'b0;
    @(negedge clk); chk("R9 oe low", int'(cidx), 0);
    oe = 1'b1;
    @(negedge clk); chk("R9 oe restored", int'(cidx), 42);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule